// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block holds an array of independent compare channels that watch one shared 64-bit free-running count. The count comes in as an input. Each channel keeps a 64-bit target. When the count equals that target, the channel raises a sticky status flag, and that flag drives the channel's own interrupt line through a per-channel interrupt enable. A channel runs in one of two modes. In one-shot mode it disarms itself after the first match. In periodic mode it re-arms by adding its period to the target.

Software reaches every channel through a word-wide register bus with single-cycle writes and combinational reads. Switching a channel on or off is not immediate. The new state appears in the enable readback only after a fixed acknowledgement delay, which stands in for a handshake with a slower timing domain. Software must poll that readback until it matches the value written before it treats the channel as started or stopped. Arming loads the target with the count at that moment plus the period. Software normally programs periods from 0xF up to 0x7FFFFFFF ticks.

Top module: `cmp_timer_array`

## Requirements
- R1: After reset every channel register reads 0 and every interrupt line is low.
- R2: The registers of channel i sit at byte address 0x200 + i*0x100, at these offsets:
  - target bits 31:0 at +0x00 and target bits 63:32 at +0x04;
  - mode bit 0 at +0x08, where 1 means periodic and 0 means one-shot;
  - the 32-bit period at +0x0C;
  - the enable bit 0 at +0x10;
  - the interrupt enable bit 0 at +0x14;
  - the status bit 0 at +0x18.
  
  Each register reads back what was written to it.
- R3: A write to the enable register changes the enable readback exactly ACK_DELAY (default 4) clock edges after the edge that takes the write. Before that edge the readback keeps its old value.
- R4: When an enable of 1 takes effect, the target becomes the count sampled on that edge plus the period.
- R5: On a match in one-shot mode, the status flag sets and the enable readback drops to 0 on the same edge. The target is left unchanged and no later match occurs.
- R6: On a match in periodic mode, the status flag sets, the period is added to the target and the channel stays enabled.
- R7: The status flag sets on a match even while the interrupt enable is 0. Interrupt line i equals status AND interrupt enable of channel i, so enabling later raises the line.
- R8: Writing 1 to the status register clears the flag and writing 0 leaves it unchanged. If a match falls on the same edge as a clearing write, the flag stays set.
- R9: A write to one channel changes no register and no interrupt line of any other channel.
- R10: Addresses outside the channel map, or at an offset not listed in R2, read as 0, and writes to them change nothing.
- R11: Once an enable of 0 has taken effect, the channel produces no further match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | 64 | Shared free-running count |
| bus_wr_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 12 | Byte address for both read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| irq_o | output | 12 | One interrupt line per channel |

## Verification
The assertions rely on the count input stepping forward and never jumping back onto a target that has already been consumed. They also rely on software issuing at most one write per cycle. The stimulus increments the count by exactly one after every clock edge and starts it just below a 32-bit boundary, so that a target crosses into the upper word. Every period it programs lies in the legal range and exceeds the acknowledgement delay, so each expected match edge is computed from the count value recorded on the write edge.

// File: rtl/cta_pkg.sv
package cta_pkg;

  // Register selector produced by the address decoder
  typedef enum logic [2:0] {
    RS_CMPL = 3'd0,
    RS_CMPH = 3'd1,
    RS_MODE = 3'd2,
    RS_PER  = 3'd3,
    RS_EN   = 3'd4,
    RS_IEN  = 3'd5,
    RS_STAT = 3'd6,
    RS_NONE = 3'd7
  } reg_sel_e;

  // Word offsets inside one channel page (software decodes these)
  localparam logic [7:0] OFF_CMPL = 8'h00;
  localparam logic [7:0] OFF_CMPH = 8'h04;
  localparam logic [7:0] OFF_MODE = 8'h08;
  localparam logic [7:0] OFF_PER  = 8'h0C;
  localparam logic [7:0] OFF_EN   = 8'h10;
  localparam logic [7:0] OFF_IEN  = 8'h14;
  localparam logic [7:0] OFF_STAT = 8'h18;

  // Page index of channel 0; each page is 256 bytes
  localparam int PAGE_BASE = 2;
  localparam int PAGE_LSB  = 8;

endpackage

// File: rtl/cta_addr_dec.sv
module cta_addr_dec
  import cta_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 12
) (
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      hit_o,
  output logic [$clog2(NUM_CH)-1:0] ch_o,
  output reg_sel_e                  sel_o
);

  localparam int PG_W = ADDR_W - PAGE_LSB;
  localparam int CH_W = $clog2(NUM_CH);

  logic [PG_W-1:0] page;
  logic [7:0]      offs;
  logic            in_rng;

  always_comb begin
    page = addr_i[ADDR_W-1:PAGE_LSB];
    offs = addr_i[PAGE_LSB-1:0];

    unique case (offs)
      OFF_CMPL: sel_o = RS_CMPL;
      OFF_CMPH: sel_o = RS_CMPH;
      OFF_MODE: sel_o = RS_MODE;
      OFF_PER:  sel_o = RS_PER;
      OFF_EN:   sel_o = RS_EN;
      OFF_IEN:  sel_o = RS_IEN;
      OFF_STAT: sel_o = RS_STAT;
      default:  sel_o = RS_NONE;
    endcase

    in_rng = (page >= PG_W'(PAGE_BASE)) && (page < PG_W'(PAGE_BASE + NUM_CH));
    ch_o   = CH_W'(page - PG_W'(PAGE_BASE));
    hit_o  = in_rng && (sel_o != RS_NONE);
  end

endmodule

// File: rtl/cta_ack_sync.sv
module cta_ack_sync #(
  parameter int ACK_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic req_val_i,
  output logic fire_o,
  output logic fire_val_o
);

  localparam int DLY_W = $clog2(ACK_DELAY + 1);
  localparam int SW    = $clog2(ACK_DELAY + 2);

  logic [DLY_W-1:0] dly_q, dly_d;
  logic             val_q, val_d;

  // A fresh request supersedes one that is about to land
  always_comb begin
    fire_o     = (dly_q == DLY_W'(1)) && !req_i;
    fire_val_o = val_q;
    dly_d      = dly_q;
    val_d      = val_q;
    if (req_i) begin
      dly_d = DLY_W'(ACK_DELAY);
      val_d = req_val_i;
    end else if (dly_q != '0) begin
      dly_d = dly_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      val_q <= 1'b0;
    end else begin
      dly_q <= dly_d;
      val_q <= val_d;
    end
  end

  // Independent edge counter since the last request, for checking only
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            since_q <= SW'(ACK_DELAY + 1);
    else if (req_i)                        since_q <= SW'(1);
    else if (since_q < SW'(ACK_DELAY + 1)) since_q <= since_q + SW'(1);
  end

  // R3
  ack_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (since_q == SW'(ACK_DELAY)));

endmodule

// File: rtl/cta_channel.sv
module cta_channel
  import cta_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ACK_DELAY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] cnt_i,
  input  logic                wr_i,
  input  reg_sel_e            sel_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] tgt_o,
  output logic                mode_o,
  output logic [DATA_W-1:0]   per_o,
  output logic                en_o,
  output logic                ien_o,
  output logic                stat_o,
  output logic                irq_o
);

  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  tgt_q, tgt_d;
  logic [DATA_W-1:0] per_q, per_d;
  logic              mode_q, mode_d;
  logic              en_q, en_d;
  logic              ien_q, ien_d;
  logic              stat_q, stat_d;

  logic w_cmpl, w_cmph, w_mode, w_per, w_en, w_ien, w_stat;
  logic match, fire, fire_val;
  logic [CNT_W-1:0] per_ext;

  always_comb begin
    w_cmpl = wr_i && (sel_i == RS_CMPL);
    w_cmph = wr_i && (sel_i == RS_CMPH);
    w_mode = wr_i && (sel_i == RS_MODE);
    w_per  = wr_i && (sel_i == RS_PER);
    w_en   = wr_i && (sel_i == RS_EN);
    w_ien  = wr_i && (sel_i == RS_IEN);
    w_stat = wr_i && (sel_i == RS_STAT);
  end

  cta_ack_sync #(.ACK_DELAY(ACK_DELAY)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (w_en),
    .req_val_i  (wdata_i[0]),
    .fire_o     (fire),
    .fire_val_o (fire_val)
  );

  always_comb begin
    per_ext = {{DATA_W{1'b0}}, per_q};
    match   = en_q && (cnt_i == tgt_q);

    mode_d = w_mode ? wdata_i[0] : mode_q;
    per_d  = w_per  ? wdata_i    : per_q;
    ien_d  = w_ien  ? wdata_i[0] : ien_q;

    // Enable: the acknowledged change first, then one-shot self-disarm
    en_d = en_q;
    if (fire)                  en_d = fire_val;
    else if (match && !mode_q) en_d = 1'b0;

    // Target: arm load, then periodic reload, then software write
    tgt_d = tgt_q;
    if (fire && fire_val)     tgt_d = cnt_i + per_ext;
    else if (match && mode_q) tgt_d = tgt_q + per_ext;
    else if (w_cmpl)          tgt_d = {tgt_q[CNT_W-1:DATA_W], wdata_i};
    else if (w_cmph)          tgt_d = {wdata_i, tgt_q[DATA_W-1:0]};

    // Status: a match wins over a clearing write
    stat_d = stat_q;
    if (match)                     stat_d = 1'b1;
    else if (w_stat && wdata_i[0]) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= '0;
      per_q  <= '0;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      ien_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      tgt_q  <= tgt_d;
      per_q  <= per_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      ien_q  <= ien_d;
      stat_q <= stat_d;
    end
  end

  assign tgt_o  = tgt_q;
  assign mode_o = mode_q;
  assign per_o  = per_q;
  assign en_o   = en_q;
  assign ien_o  = ien_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q && ien_q;

  // R4
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (tgt_q == $past(cnt_i) + $past(per_ext)));

  // R5
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !mode_q && !fire) |=> !en_q);

  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode_q && !fire) |=> (tgt_q == $past(tgt_q) + $past(per_ext)));

  // R7
  match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> stat_q);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(match) || $past(w_ien)));

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(w_stat && wdata_i[0])) |=> stat_q);

  // R11
  disarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(fire) || $past(match && !mode_q)));

endmodule

// File: rtl/cmp_timer_array.sv
module cmp_timer_array
  import cta_pkg::*;
#(
  parameter int NUM_CH    = 12,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12,
  parameter int ACK_DELAY = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] cnt_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_CH-1:0]   irq_o
);

  localparam int CNT_W = 2 * DATA_W;
  localparam int CH_W  = $clog2(NUM_CH);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic            hit;
  logic [CH_W-1:0] ch;
  reg_sel_e        sel;

  cta_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr_i (bus_addr_i),
    .hit_o  (hit),
    .ch_o   (ch),
    .sel_o  (sel)
  );

  logic [CNT_W-1:0]  tgt_a [NUM_CH];
  logic [DATA_W-1:0] per_a [NUM_CH];
  logic [NUM_CH-1:0] mode_v, en_v, ien_v, stat_v, wr_v;

  for (genvar i = 0; i < NUM_CH; i++) begin : gen_ch
    assign wr_v[i] = bus_wr_i && hit && (ch == CH_W'(i));

    cta_channel #(.DATA_W(DATA_W), .ACK_DELAY(ACK_DELAY)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .cnt_i   (cnt_i),
      .wr_i    (wr_v[i]),
      .sel_i   (sel),
      .wdata_i (bus_wdata_i),
      .tgt_o   (tgt_a[i]),
      .mode_o  (mode_v[i]),
      .per_o   (per_a[i]),
      .en_o    (en_v[i]),
      .ien_o   (ien_v[i]),
      .stat_o  (stat_v[i]),
      .irq_o   (irq_o[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        RS_CMPL: bus_rdata_o = tgt_a[ch][DATA_W-1:0];
        RS_CMPH: bus_rdata_o = tgt_a[ch][CNT_W-1:DATA_W];
        RS_MODE: bus_rdata_o = {{(DATA_W-1){1'b0}}, mode_v[ch]};
        RS_PER:  bus_rdata_o = per_a[ch];
        RS_EN:   bus_rdata_o = {{(DATA_W-1){1'b0}}, en_v[ch]};
        RS_IEN:  bus_rdata_o = {{(DATA_W-1){1'b0}}, ien_v[ch]};
        RS_STAT: bus_rdata_o = {{(DATA_W-1){1'b0}}, stat_v[ch]};
        default: bus_rdata_o = '0;
      endcase
    end
  end

  // R9
  one_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(wr_v));

endmodule

// File: tb/sim_cmp_timer_array.sv
`timescale 1ns/100ps
module sim_cmp_timer_array;

  localparam int NUM_CH = 12;
  localparam int DLY    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        wr;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [11:0] irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [63:0] last_wcnt;

  always #2.5 clk = ~clk;

  cmp_timer_array u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // Count changes 1 ns after each rising edge
  initial begin
    cnt = 64'h0000_0000_FFFF_FF80;
    forever begin
      @(posedge clk);
      #1 cnt <= cnt + 64'd1;
    end
  end

  function automatic logic [11:0] ra(input int c, input logic [7:0] off);
    return 12'h200 + 12'(c * 256) + {4'h0, off};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d; last_wcnt = cnt;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #0.2 d = rdata;
  endtask

  task automatic wait_cnt(input logic [63:0] v);
    while (cnt != v) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c += 11) begin
      rd_reg(ra(c, 8'h00), d); chk("R1 cmp lo", d, 0);
      rd_reg(ra(c, 8'h08), d); chk("R1 mode", d, 0);
      rd_reg(ra(c, 8'h10), d); chk("R1 enable", d, 0);
      rd_reg(ra(c, 8'h18), d); chk("R1 status", d, 0);
    end
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr_reg(ra(3, 8'h08), 32'h1);
    wr_reg(ra(3, 8'h0C), 32'h7FFF_FFFF);
    wr_reg(ra(3, 8'h14), 32'h1);
    wr_reg(ra(3, 8'h04), 32'hA5A5_0001);
    rd_reg(ra(3, 8'h08), d); chk("R2 mode", d, 1);
    rd_reg(ra(3, 8'h0C), d); chk("R2 period", d, 32'h7FFF_FFFF);
    rd_reg(ra(3, 8'h14), d); chk("R2 ien", d, 1);
    rd_reg(ra(3, 8'h04), d); chk("R2 cmp hi", d, 32'hA5A5_0001);
    rd_reg(ra(4, 8'h08), d); chk("R9 neighbour mode", d, 0);
    rd_reg(ra(4, 8'h0C), d); chk("R9 neighbour period", d, 0);
    rd_reg(ra(2, 8'h04), d); chk("R9 neighbour cmp hi", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr_reg(12'h21C, 32'hFFFF_FFFF);
    wr_reg(12'h0F0, 32'hFFFF_FFFF);
    wr_reg(12'hE08, 32'hFFFF_FFFF);
    rd_reg(12'h21C, d); chk("R10 bad offset", d, 0);
    rd_reg(12'h0F0, d); chk("R10 below map", d, 0);
    rd_reg(12'hE08, d); chk("R10 above map", d, 0);
    rd_reg(ra(0, 8'h00), d); chk("R10 ch0 cmp lo untouched", d, 0);
    rd_reg(ra(0, 8'h18), d); chk("R10 ch0 status untouched", d, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    logic [63:0] t;
    wr_reg(ra(1, 8'h0C), 32'h20);
    wr_reg(ra(1, 8'h14), 32'h1);
    wr_reg(ra(1, 8'h10), 32'h1);
    rd_reg(ra(1, 8'h10), d); chk("R3 readback held 0", d, 0);
    for (int j = 1; j < DLY; j++) begin
      @(negedge clk);
      rd_reg(ra(1, 8'h10), d); chk("R3 readback still 0", d, 0);
    end
    @(negedge clk);
    rd_reg(ra(1, 8'h10), d); chk("R3 readback 1 after delay", d, 1);
    t = last_wcnt + 64'(DLY) + 64'h20;
    rd_reg(ra(1, 8'h00), d); chk("R4 target lo", d, t[31:0]);
    rd_reg(ra(1, 8'h04), d); chk("R4 target hi", d, t[63:32]);
    wait_cnt(t);
    rd_reg(ra(1, 8'h18), d); chk("R5 no status before match", d, 0);
    @(negedge clk);
    rd_reg(ra(1, 8'h18), d); chk("R5 status on match", d, 1);
    chk("R7 irq line 1", irq, 12'h002);
    rd_reg(ra(1, 8'h10), d); chk("R5 enable dropped", d, 0);
    rd_reg(ra(0, 8'h18), d); chk("R9 ch0 status", d, 0);
    wr_reg(ra(1, 8'h18), 32'h1);
    wait_cnt(t + 64'h60);
    rd_reg(ra(1, 8'h18), d); chk("R5 no second match", d, 0);
    rd_reg(ra(1, 8'h00), d); chk("R5 target kept", d, t[31:0]);
  endtask

  task automatic t_noien();
    logic [31:0] d;
    logic [63:0] t;
    wr_reg(ra(2, 8'h0C), 32'h10);
    wr_reg(ra(2, 8'h10), 32'h1);
    t = last_wcnt + 64'(DLY) + 64'h10;
    wait_cnt(t);
    @(negedge clk);
    rd_reg(ra(2, 8'h18), d); chk("R7 status without ien", d, 1);
    chk("R7 irq masked", irq, 0);
    wr_reg(ra(2, 8'h14), 32'h1);
    chk("R7 irq after ien", irq, 12'h004);
    wr_reg(ra(2, 8'h18), 32'h0);
    rd_reg(ra(2, 8'h18), d); chk("R8 write 0 keeps", d, 1);
    wr_reg(ra(2, 8'h18), 32'h1);
    rd_reg(ra(2, 8'h18), d); chk("R8 write 1 clears", d, 0);
    chk("R8 irq cleared", irq, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    logic [63:0] t;
    wr_reg(ra(5, 8'h08), 32'h1);
    wr_reg(ra(5, 8'h0C), 32'h10);
    wr_reg(ra(5, 8'h14), 32'h1);
    wr_reg(ra(5, 8'h10), 32'h1);
    t = last_wcnt + 64'(DLY) + 64'h10;
    wait_cnt(t);
    @(negedge clk);
    rd_reg(ra(5, 8'h18), d); chk("R6 first match", d, 1);
    rd_reg(ra(5, 8'h00), d); chk("R6 target advanced", d, 32'(t + 64'h10));
    wr_reg(ra(5, 8'h18), 32'h1);
    wait_cnt(t + 64'h10);
    rd_reg(ra(5, 8'h18), d); chk("R6 clear before second", d, 0);
    @(negedge clk);
    rd_reg(ra(5, 8'h18), d); chk("R6 second match", d, 1);
    rd_reg(ra(5, 8'h04), d); chk("R6 target hi", d, 32'((t + 64'h20) >> 32));
    rd_reg(ra(5, 8'h10), d); chk("R6 stays enabled", d, 1);
    wr_reg(ra(5, 8'h18), 32'h1);
    wait_cnt(t + 64'h20);
    wr_reg(ra(5, 8'h18), 32'h1);
    rd_reg(ra(5, 8'h18), d); chk("R8 match beats clear", d, 1);
    chk("R6 irq line 5", irq, 12'h020);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr_reg(ra(5, 8'h10), 32'h0);
    rd_reg(ra(5, 8'h10), d); chk("R3 disable not yet", d, 1);
    repeat (DLY) @(negedge clk);
    rd_reg(ra(5, 8'h10), d); chk("R11 disabled", d, 0);
    wr_reg(ra(5, 8'h18), 32'h1);
    repeat (60) @(negedge clk);
    rd_reg(ra(5, 8'h18), d); chk("R11 no match after disable", d, 0);
    chk("R11 irq quiet", irq, 0);
  endtask

  initial begin
    #400_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = '0; wdata = '0; last_wcnt = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_unmapped();
    t_oneshot();
    t_noien();
    t_periodic();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule